// File: doc/BRIEF.md
# Prioritised Five-Source Interrupt Controller

This block gathers interrupt requests from five sources and hands the CPU at most one of them at a time. The sources are two active-low external pins, two timer overflow pulses and a serial-port event line. Requests are latched into flag bits. Each flag is gated by its own enable bit and by a global enable bit. The eligible requests then go to a resolver that knows two priority levels. A request is presented to the CPU as a registered strobe with a 3-bit vector index.

Software reaches the block through a simple byte-wide register port with three locations: enables, flags with trigger control, and priority level. The CPU answers a presented request with an acknowledge pulse and later ends the handler with a return pulse. The controller tracks one in-service bit per level. This lets a high-level request preempt a low-level handler, while nothing at the same or a lower level can interrupt a running handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Vector indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial. Among eligible requests at one level, the lowest index wins.
- R2: Enable register at address 0xA8: bit 7 global, bit 4 serial, bit 3 timer 1, bit 2 external 1, bit 1 timer 0, bit 0 external 0. Unused bits read 0. Priority register at 0xB8: bits 4..0 by vector index, and bits 7..5 read 0. Read data appears one cycle after the address.
- R3: A source is presented only when its enable bit and bit 7 of 0xA8 are both 1. A disabled source's flag still latches, and it is presented once enabled.
- R4: A source whose bit in 0xB8 is 1 is high level and wins over every low-level request.
- R5: The flag register at 0x88 holds: bit 0 external 0 mode, bit 1 external 0 flag, bit 2 external 1 mode, bit 3 external 1 flag, bit 4 timer 0 run, bit 5 timer 0 flag, bit 6 timer 1 run, bit 7 timer 1 flag. With mode 0, the external flag follows the synchronised pin (low = request). With mode 1, the external flag is set by a falling edge only.
- R6: An acknowledge clears the flag of the acknowledged source when that source is a timer or an edge-mode external pin. The serial request is never cleared by the controller.
- R7: When a hardware set of a flag and a software write of 0 to that flag happen in the same cycle, the flag ends at 1.
- R8: While a low-level handler is in service, only a high-level request is presented. While a high-level handler is in service, no request is presented.
- R9: A return pulse clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: After reset, all three registers read 0 and no request is presented.
- R11: The request output is 0 in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext0_n | input | 1 | External request pin 0, active low, asynchronous |
| ext1_n | input | 1 | External request pin 1, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse, synchronous |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse, synchronous |
| ser_req | input | 1 | Serial-port request level |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Request presented to the CPU |
| irq_vec | output | 3 | Vector index of the presented request |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_ret | input | 1 | CPU return-from-handler pulse |

## Verification
Two things can land on the same flag bit in one cycle: a hardware overflow pulse setting a timer flag, and a software write to the flag register clearing it. The bench drives the pulse and a write of zero to 0x88 on the same clock edge. It then reads the register back and expects the timer flag to be set. A control case, a write of zero with no pulse, must read back clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC      = 5;
  localparam int VEC_W     = 3;
  localparam int REG_W     = 8;
  localparam logic [REG_W-1:0] ADDR_EN   = 8'hA8;
  localparam logic [REG_W-1:0] ADDR_FLAG = 8'h88;
  localparam logic [REG_W-1:0] ADDR_PRIO = 8'hB8;
  localparam logic [REG_W-1:0] EN_MASK   = 8'h9F;
  localparam int NPIN      = 2;
  localparam int NTMR      = 2;
endpackage

// File: rtl/intc_pin_sync.sv
module intc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic lvl_low,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl_low = ~chain[STAGES-1];
  assign fall    = prev & ~chain[STAGES-1];
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N  = 5,
  parameter int VW = 3
) (
  input  logic [N-1:0]  elig,
  input  logic [N-1:0]  prio,
  output logic          grant,
  output logic [VW-1:0] gvec,
  output logic          glvl
);
  logic [N-1:0] hi;
  logic [N-1:0] pick;

  always_comb begin
    hi    = elig & prio;
    glvl  = |hi;
    pick  = glvl ? hi : elig;
    grant = |pick;
    gvec  = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (pick[i]) gvec = VW'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext0_n,
  input  logic             ext1_n,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             ser_req,
  input  logic [REG_W-1:0] sfr_addr,
  input  logic             sfr_wr,
  input  logic [REG_W-1:0] sfr_wdata,
  output logic [REG_W-1:0] sfr_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic             irq_ret
);
  logic [NPIN-1:0]  pin_in, pin_low, pin_fall;
  logic [NTMR-1:0]  tmr_ovf;
  logic [REG_W-1:0] en_q, flag_q, flag_n;
  logic [NSRC-1:0]  prio_q, pend, elig, ack_hit;
  logic             isv_hi, isv_lo, isv_hi_n, isv_lo_n;
  logic             wr_en, wr_flag, wr_prio, ack_ok, ack_lvl;
  logic             grant, glvl, allow;
  logic [VEC_W-1:0] gvec;

  assign pin_in  = {ext1_n, ext0_n};
  assign tmr_ovf = {tmr1_ovf, tmr0_ovf};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    intc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .pin_n  (pin_in[g]),
      .lvl_low(pin_low[g]),
      .fall   (pin_fall[g])
    );
  end

  assign wr_en   = sfr_wr && (sfr_addr == ADDR_EN);
  assign wr_flag = sfr_wr && (sfr_addr == ADDR_FLAG);
  assign wr_prio = sfr_wr && (sfr_addr == ADDR_PRIO);
  assign ack_ok  = irq_ack && irq_req;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      ack_hit[i] = ack_ok && (irq_vec == VEC_W'(i));
    end
  end
  assign ack_lvl = |(ack_hit & prio_q);

  // Flag update order: software write, then acknowledge clear, then hardware set.
  always_comb begin
    flag_n = flag_q;
    if (wr_flag) flag_n = sfr_wdata;
    for (int k = 0; k < NPIN; k++) begin
      if (!flag_q[2*k]) begin
        flag_n[2*k+1] = pin_low[k];
      end else begin
        if (ack_hit[2*k]) flag_n[2*k+1] = 1'b0;
        if (pin_fall[k])  flag_n[2*k+1] = 1'b1;
      end
      if (ack_hit[2*k+1]) flag_n[2*k+5] = 1'b0;
      if (tmr_ovf[k])     flag_n[2*k+5] = 1'b1;
    end
  end

  assign pend = {ser_req, flag_q[7], flag_q[3], flag_q[5], flag_q[1]};
  assign elig = pend & en_q[NSRC-1:0] & {NSRC{en_q[7]}};

  intc_arbiter #(.N(NSRC), .VW(VEC_W)) u_arb (
    .elig (elig),
    .prio (prio_q),
    .grant(grant),
    .gvec (gvec),
    .glvl (glvl)
  );

  assign allow = grant && !isv_hi && (!isv_lo || glvl);

  always_comb begin
    isv_hi_n = isv_hi;
    isv_lo_n = isv_lo;
    if (irq_ret) begin
      if (isv_hi) isv_hi_n = 1'b0;
      else        isv_lo_n = 1'b0;
    end
    if (ack_ok) begin
      if (ack_lvl) isv_hi_n = 1'b1;
      else         isv_lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      flag_q    <= '0;
      prio_q    <= '0;
      isv_hi    <= 1'b0;
      isv_lo    <= 1'b0;
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      sfr_rdata <= '0;
    end else begin
      if (wr_en)   en_q   <= sfr_wdata & EN_MASK;
      if (wr_prio) prio_q <= sfr_wdata[NSRC-1:0];
      flag_q  <= flag_n;
      isv_hi  <= isv_hi_n;
      isv_lo  <= isv_lo_n;
      irq_req <= allow && !irq_ack;
      if (allow) irq_vec <= gvec;
      case (sfr_addr)
        ADDR_EN:   sfr_rdata <= en_q;
        ADDR_FLAG: sfr_rdata <= flag_q;
        ADDR_PRIO: sfr_rdata <= REG_W'(prio_q);
        default:   sfr_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_req,
  input logic [2:0] irq_vec,
  input logic       irq_ack,
  input logic       glob_en,
  input logic       isv_hi,
  input logic       tf0,
  input logic       tmr0_ovf,
  input logic       sfr_wr
);
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec <= 3'd4)); // R1

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(glob_en)); // R3

  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req); // R11

  AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (rst)
    isv_hi |-> !irq_req); // R8

  AST_ACK_CLEARS_TMR: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && irq_vec == 3'd1 && !tmr0_ovf && !sfr_wr) |=> !tf0); // R6
endmodule

bind prio_irq_ctrl intc_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq_req (irq_req),
  .irq_vec (irq_vec),
  .irq_ack (irq_ack),
  .glob_en (en_q[7]),
  .isv_hi  (isv_hi),
  .tf0     (flag_q[5]),
  .tmr0_ovf(tmr0_ovf),
  .sfr_wr  (sfr_wr)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext0_n = 1'b1, ext1_n = 1'b1;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, ser_req = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_rdata;
  logic       irq_req;
  logic [2:0] irq_vec;
  logic       irq_ack = 1'b0, irq_ret = 1'b0;
  int         total = 0, bad = 0;
  bit         done = 1'b0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .ext0_n(ext0_n), .ext1_n(ext1_n),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .ser_req(ser_req),
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    ext0_n = 1'b1; ext1_n = 1'b1; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
    ser_req = 1'b0; sfr_wr = 1'b0; irq_ack = 1'b0; irq_ret = 1'b0;
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1; tick(1); sfr_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; tick(1); d = sfr_rdata;
  endtask

  task automatic pulse(input bit t1, input bit t0);
    tmr0_ovf = t0; tmr1_ovf = t1; tick(1); tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; tick(1); irq_ret = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 req", {7'b0, irq_req}, 8'h00);
    rd_reg(8'hA8, rd); check("R10 en", rd, 8'h00);
    rd_reg(8'h88, rd); check("R10 flag", rd, 8'h00);
    rd_reg(8'hB8, rd); check("R10 prio", rd, 8'h00);
  endtask

  task automatic t_regs();
    do_reset();
    wr(8'hA8, 8'hFF); rd_reg(8'hA8, rd); check("R2 en mask", rd, 8'h9F);
    wr(8'hB8, 8'hFF); rd_reg(8'hB8, rd); check("R2 prio mask", rd, 8'h1F);
    wr(8'h88, 8'h55); rd_reg(8'h88, rd); check("R5 flag ctrl", rd, 8'h55);
  endtask

  task automatic t_timer();
    do_reset();
    wr(8'hA8, 8'h82);
    pulse(1'b0, 1'b1); tick(1);
    check("R1 t0 req", {7'b0, irq_req}, 8'h01);
    check("R1 t0 vec", {5'b0, irq_vec}, 8'h01);
    ack();
    check("R11 drop", {7'b0, irq_req}, 8'h00);
    rd_reg(8'h88, rd); check("R6 t0 cleared", rd, 8'h00);
    ret();
  endtask

  task automatic t_global();
    do_reset();
    wr(8'hA8, 8'h02);
    pulse(1'b0, 1'b1); tick(3);
    check("R3 gated", {7'b0, irq_req}, 8'h00);
    rd_reg(8'h88, rd); check("R3 flag latched", rd, 8'h20);
    wr(8'hA8, 8'h82); tick(1);
    check("R3 released", {6'b0, irq_req, irq_vec == 3'd1}, 8'h03);
  endtask

  task automatic t_order();
    do_reset();
    wr(8'hA8, 8'h8F);
    pulse(1'b1, 1'b1); tick(1);
    check("R1 order vec", {5'b0, irq_vec}, 8'h01);
    ack(); tick(2);
    check("R8 same level blocked", {7'b0, irq_req}, 8'h00);
    ret(); tick(1);
    check("R1 next req", {7'b0, irq_req}, 8'h01);
    check("R1 next vec", {5'b0, irq_vec}, 8'h03);
  endtask

  task automatic t_prio();
    do_reset();
    wr(8'hA8, 8'h8A); wr(8'hB8, 8'h08);
    pulse(1'b1, 1'b1); tick(1);
    check("R4 high wins", {5'b0, irq_vec}, 8'h03);
  endtask

  task automatic t_preempt();
    do_reset();
    wr(8'hA8, 8'h8A); wr(8'hB8, 8'h08);
    pulse(1'b0, 1'b1); tick(1);
    check("R8 low vec", {5'b0, irq_vec}, 8'h01);
    ack();
    pulse(1'b1, 1'b0); tick(1);
    check("R8 preempt", {6'b0, irq_req, irq_vec == 3'd3}, 8'h03);
    ack();
    pulse(1'b0, 1'b1); tick(3);
    check("R8 high blocks", {7'b0, irq_req}, 8'h00);
    ret(); tick(2);
    check("R9 low still active", {7'b0, irq_req}, 8'h00);
    ret(); tick(1);
    check("R9 low cleared", {6'b0, irq_req, irq_vec == 3'd1}, 8'h03);
  endtask

  task automatic t_edge();
    do_reset();
    wr(8'hA8, 8'h81); wr(8'h88, 8'h01);
    ext0_n = 1'b0; tick(5);
    check("R5 edge req", {6'b0, irq_req, irq_vec == 3'd0}, 8'h03);
    ack();
    rd_reg(8'h88, rd); check("R6 edge cleared", rd, 8'h01);
    ret(); tick(4);
    check("R5 no retrigger", {7'b0, irq_req}, 8'h00);
    ext0_n = 1'b1; tick(2);
  endtask

  task automatic t_level();
    do_reset();
    wr(8'hA8, 8'h84);
    ext1_n = 1'b0; tick(5);
    check("R5 level req", {6'b0, irq_req, irq_vec == 3'd2}, 8'h03);
    ack();
    rd_reg(8'h88, rd); check("R5 level flag", rd, 8'h08);
    ret(); tick(2);
    check("R5 level again", {6'b0, irq_req, irq_vec == 3'd2}, 8'h03);
    ext1_n = 1'b1; tick(5);
    check("R5 level gone", {7'b0, irq_req}, 8'h00);
  endtask

  task automatic t_collide();
    do_reset();
    wr(8'hA8, 8'h02);
    tmr0_ovf = 1'b1; wr(8'h88, 8'h00); tmr0_ovf = 1'b0;
    rd_reg(8'h88, rd); check("R7 hw set wins", rd, 8'h20);
    wr(8'h88, 8'h00);
    rd_reg(8'h88, rd); check("R7 sw clear alone", rd, 8'h00);
  endtask

  task automatic t_serial();
    do_reset();
    wr(8'hA8, 8'h90);
    ser_req = 1'b1; tick(1);
    check("R1 serial vec", {6'b0, irq_req, irq_vec == 3'd4}, 8'h03);
    ack(); ret(); tick(1);
    check("R6 serial kept", {6'b0, irq_req, irq_vec == 3'd4}, 8'h03);
    ser_req = 1'b0; tick(2);
    check("R6 serial gone", {7'b0, irq_req}, 8'h00);
  endtask

  initial begin
    tick(1);
    t_reset();
    t_regs();
    t_timer();
    t_global();
    t_order();
    t_prio();
    t_preempt();
    t_edge();
    t_level();
    t_collide();
    t_serial();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule